// File: doc/BRIEF.md
# Delayed Address Parity Checker

This block guards the address and command lines of a registered memory-module buffer. On every clock edge at which at least one chip-select line is active, it takes the address/command word and reduces it to one parity bit: the least significant bit of the sum of all its bits. The host sends its own parity bit for that word one clock later. The block compares the two at that next edge.

A difference between the two bits drives the active-low error output `err_n` low. This output is meant to enable an open-drain pull-down at the pad. The error indication lasts a fixed number of cycles, and a new mismatch during that time starts the count again.

Cycles with no chip select active are never checked. Chip-select, clock-enable and termination-control lines are not part of the parity word. Only the address/command vector enters the sum.

Top module: `apc_parity_checker`

## Requirements
- R1: The computed parity is the XOR of all `ADDR_W` bits of `cmd_addr`, which is the LSB of their sum. The host parity bit matches when it equals that value.
- R2: The parity computed from the word captured at edge k is compared with the `par_in` value sampled at edge k+1, and with no other value of `par_in`.
- R3: A mismatch found at edge k+1 drives `err_n` to 0 in the cycle after that edge.
- R4: A word captured while every `cs_n` bit is 1 (no chip select active) is not checked, whatever `par_in` is one cycle later.
- R5: A word is checked when any single `cs_n` bit is 0. The value of the chip-select vector does not change the computed parity.
- R6: After one isolated mismatch, `err_n` stays 0 for exactly `ERR_HOLD` cycles (default 2) and then returns to 1.
- R7: A further mismatch while `err_n` is 0 restarts the hold, so `err_n` stays 0 for `ERR_HOLD` cycles after the last mismatch.
- R8: The synchronous reset `rst` (active high) clears the capture stage and the hold. `err_n` is 1 after any edge at which `rst` is 1. A word captured before reset is never checked after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is captured on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_addr | input | ADDR_W | Address/command word covered by parity |
| cs_n | input | CS_W | Chip-select lines, active low |
| par_in | input | 1 | Host parity bit for the word presented one cycle earlier |
| err_n | output | 1 | Parity error, active low (pull-down enable) |

## Verification
The bench builds the block with the defaults: a 22-bit address/command word, four chip-select lines and a two-cycle hold. With these values a single mismatch, two mismatches in a row, and a mismatch that falls on the last cycle of a hold are all short enough to reach in a few cycles, so every restart case appears. Random traffic with a biased chip-select mix and a 30% rate of wrong parity exercises the cases that directed tests miss. These include skipped cycles lying between checked ones and reset arriving between capture and comparison.

// File: rtl/apc_pkg.sv
package apc_pkg;

    // One entry of the capture pipeline: whether the word was chip-select
    // qualified, and the parity that was computed from it.
    typedef struct packed {
        logic valid;
        logic par;
    } apc_stage_t;

    localparam apc_stage_t APC_STAGE_IDLE = '{valid: 1'b0, par: 1'b0};

    // Width needed to count from 0 up to n inclusive.
    function automatic int apc_cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/apc_parity_tree.sv
module apc_parity_tree #(
    parameter int W = 22
) (
    input  logic [W-1:0] bits,
    output logic         par
);
    localparam int LG = (W > 1) ? $clog2(W) : 0;
    localparam int P  = 1 << LG;

    // Balanced XOR tree: level 0 holds the zero-padded leaves and every
    // following level halves the width.
    for (genvar lv = 0; lv <= LG; lv++) begin : g_lvl
        logic [(P >> lv)-1:0] v;
        if (lv == 0) begin : g_leaf
            assign v = P'(bits);
        end else begin : g_node
            for (genvar k = 0; k < (P >> lv); k++) begin : g_x
                assign v[k] = g_lvl[lv-1].v[2*k] ^ g_lvl[lv-1].v[2*k+1];
            end
        end
    end

    assign par = g_lvl[LG].v[0];

endmodule

// File: rtl/apc_capture_stage.sv
module apc_capture_stage
    import apc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       par_calc,
    output apc_stage_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= APC_STAGE_IDLE;
        end else begin
            q <= '{valid: sel, par: par_calc};
        end
    end

endmodule

// File: rtl/apc_err_stretch.sv
module apc_err_stretch
    import apc_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic err_n
);
    localparam int CW = apc_cnt_width(HOLD);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (trig) begin
            remain <= CW'(HOLD);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign err_n = (remain == '0);

endmodule

// File: rtl/apc_parity_checker.sv
module apc_parity_checker
    import apc_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int CS_W     = 4,
    parameter int ERR_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CS_W-1:0]   cs_n,
    input  logic              par_in,
    output logic              err_n
);
    logic       par_calc;
    logic       any_sel;
    apc_stage_t stage_q;
    logic       mismatch;

    apc_parity_tree #(.W(ADDR_W)) u_tree (
        .bits (cmd_addr),
        .par  (par_calc)
    );

    assign any_sel = ~&cs_n;

    apc_capture_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .sel      (any_sel),
        .par_calc (par_calc),
        .q        (stage_q)
    );

    // The host bit present now belongs to the word captured one edge ago.
    assign mismatch = stage_q.valid & (stage_q.par ^ par_in);

    apc_err_stretch #(.HOLD(ERR_HOLD)) u_stretch (
        .clk   (clk),
        .rst   (rst),
        .trig  (mismatch),
        .err_n (err_n)
    );

endmodule

// File: rtl/apc_parity_checker_chk.sv
module apc_parity_checker_chk #(
    parameter int ADDR_W   = 22,
    parameter int CS_W     = 4,
    parameter int ERR_HOLD = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [CS_W-1:0]   cs_n,
    input logic              par_in,
    input logic              err_n,
    input logic              mismatch
);
    localparam int SW = $clog2(ERR_HOLD + 2);

    // Edges since the last detected mismatch, saturating at ERR_HOLD.
    logic [SW-1:0] since;
    always_ff @(posedge clk) begin
        if (rst) since <= SW'(ERR_HOLD);
        else if (mismatch) since <= '0;
        else if (since < SW'(ERR_HOLD)) since <= since + 1'b1;
    end

    AST_RST_RELEASE: assert property (@(posedge clk) rst |=> err_n); // R8

    AST_FALL_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |-> !(&$past(cs_n, 2))); // R4

    AST_FALL_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |-> ($past(par_in) != (^$past(cmd_addr, 2)))); // R3

    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!(&cs_n)) ##1 (par_in != (^$past(cmd_addr))) |=> !err_n); // R2

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        err_n == (since >= SW'(ERR_HOLD))); // R6

endmodule

bind apc_parity_checker apc_parity_checker_chk #(
    .ADDR_W   (ADDR_W),
    .CS_W     (CS_W),
    .ERR_HOLD (ERR_HOLD)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_addr (cmd_addr),
    .cs_n     (cs_n),
    .par_in   (par_in),
    .err_n    (err_n),
    .mismatch (mismatch)
);

// File: tb/sim_apc_parity_checker.sv
`timescale 1ns/1ps
module sim_apc_parity_checker;
    localparam int ADDR_W   = 22;
    localparam int CS_W     = 4;
    localparam int ERR_HOLD = 2;
    localparam int MAX_CYC  = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CS_W-1:0]   cs_n = '1;
    logic              par_in = 1'b0;
    logic              err_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    bit          m_valid = 0;
    bit          m_par = 0;
    int          m_cnt = 0;
    logic [ADDR_W-1:0] prev_cmd = '0;

    always #10 clk = ~clk;

    apc_parity_checker #(.ADDR_W(ADDR_W), .CS_W(CS_W), .ERR_HOLD(ERR_HOLD)) u0 (
        .clk(clk), .rst(rst), .cmd_addr(cmd_addr), .cs_n(cs_n),
        .par_in(par_in), .err_n(err_n)
    );

    // LSB of the sum of the word's bits
    function automatic bit sum_lsb(input logic [ADDR_W-1:0] w);
        int s = 0;
        for (int i = 0; i < ADDR_W; i++) s += int'(w[i]);
        return s[0];
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: err_n=%0b expected %0b", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the model, then compare err_n.
    task automatic step(input string tag, input bit r,
                        input logic [ADDR_W-1:0] c,
                        input logic [CS_W-1:0] s, input bit p);
        bit mism;
        @(negedge clk);
        rst = r; cmd_addr = c; cs_n = s; par_in = p;
        @(posedge clk);
        if (r) begin
            m_valid = 0; m_par = 0; m_cnt = 0;
        end else begin
            mism = m_valid && (p != m_par);
            if (mism) m_cnt = ERR_HOLD;
            else if (m_cnt > 0) m_cnt--;
            m_valid = !(&s);
            m_par = sum_lsb(c);
        end
        prev_cmd = c;
        #1;
        check(tag, err_n, m_cnt == 0);
    endtask

    initial begin
        #(20.0 * MAX_CYC);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: err_n=%0b expected run to finish", err_n);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a, b;
        void'($urandom(32'd4711));
        // R8: reset state
        for (int i = 0; i < 3; i++) step("R8 reset", 1, '0, '1, 0);

        // R1/R2: matching parity one cycle later, no error
        a = 22'h2A5F3C;
        step("R1 capture", 0, a, 4'b1110, 0);
        step("R1 match", 0, '0, '1, sum_lsb(a));
        step("R1 quiet", 0, '0, '1, 0);

        // R2: wrong bit in the capture cycle, right bit one cycle later
        a = 22'h000001;
        step("R2 capture with wrong same-cycle bit", 0, a, 4'b1101, ~sum_lsb(a));
        step("R2 delayed bit governs", 0, '0, '1, sum_lsb(a));

        // R3/R6: single mismatch, low for exactly ERR_HOLD cycles
        a = 22'h3FFFFF;
        step("R3 capture", 0, a, 4'b1011, 0);
        step("R3 mismatch flags", 0, '0, '1, ~sum_lsb(a));
        step("R6 hold", 0, '0, '1, 0);
        step("R6 release", 0, '0, '1, 0);
        step("R6 stays released", 0, '0, '1, 1);

        // R4: no chip select, wrong parity ignored
        a = 22'h155555;
        step("R4 unselected capture", 0, a, '1, 0);
        step("R4 unchecked", 0, '0, '1, ~sum_lsb(a));
        step("R4 still high", 0, '0, '1, 0);

        // R5: same word, different chip-select patterns, same parity
        a = 22'h0ABCDE;
        step("R5 cs 0111", 0, a, 4'b0111, 0);
        step("R5 cs 0000", 0, a, 4'b0000, sum_lsb(a));
        step("R5 match after cs 0000", 0, '0, '1, sum_lsb(a));
        step("R5 quiet", 0, '0, '1, 0);

        // R7: back-to-back mismatches extend the hold
        a = 22'h111111; b = 22'h222223;
        step("R7 capture a", 0, a, 4'b1110, 0);
        step("R7 mismatch a, capture b", 0, b, 4'b1110, ~sum_lsb(a));
        step("R7 mismatch b restarts", 0, '0, '1, ~sum_lsb(b));
        step("R7 still low", 0, '0, '1, 0);
        step("R7 released", 0, '0, '1, 0);

        // R8: reset between capture and compare drops the check
        a = 22'h0F0F0F;
        step("R8 capture", 0, a, 4'b1110, 0);
        step("R8 reset on compare", 1, '0, '1, ~sum_lsb(a));
        step("R8 no stale check", 0, '0, '1, ~sum_lsb(a));
        // R8: reset during a hold releases err_n
        step("R8 capture 2", 0, a, 4'b1110, 0);
        step("R3 mismatch 2", 0, '0, '1, ~sum_lsb(a));
        step("R8 reset in hold", 1, '0, '1, 0);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [ADDR_W-1:0] c;
            logic [CS_W-1:0] s;
            bit p, r;
            c = ADDR_W'($urandom);
            s = ($urandom_range(0, 2) == 0) ? '1 : CS_W'($urandom);
            p = ($urandom_range(0, 9) < 7) ? sum_lsb(prev_cmd) : ~sum_lsb(prev_cmd);
            r = ($urandom_range(0, 99) == 0);
            step("R3/R6/R7 random", r, c, s, p);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule